// File: doc/BRIEF.md
# Processor interrupt pin conditioner

This block sits between a handful of raw processor control pins and the core. It receives pin updates as events (a valid strobe, a pin index and the new level), keeps the last level seen on every pin, and reacts only when an event carries a level different from the stored one. Depending on the pin, a change is mirrored into a pending-interrupt bit, latched on a falling edge, turned into a halt, or turned into a one-cycle reset request.

The core reads a four-bit pending vector plus a summary request line, a halt line, and single-cycle pulses announcing a newly latched machine check and a hard-reset request. The latched machine check stays pending until the core pulses an acknowledge. Pin events are assumed synchronous to the block clock; each event is evaluated once, on the clock edge where the strobe is high, and all results appear registered after that edge.

Top module: `pin_irq_cond`

## Requirements
- R1: Stored pin levels (`pin_lvl`, bit i = pin i) reset to zero and update only when an event's level differs from the stored level; an event that repeats the stored level changes no output.
- R2: Pin index 0 (external interrupt, active high) copies its new level into pending bit 0.
- R3: Pin index 1 (system management interrupt, active high) copies its new level into pending bit 1.
- R4: Pin index 2 (machine check) sets pending bit 2 and pulses `mck_req` for exactly one cycle only on a 1-to-0 change; a 0-to-1 change only updates the stored level.
- R5: `mck_ack` clears pending bit 2 on the next edge; if a machine-check falling edge arrives in the same cycle, the bit stays set.
- R6: Pin index 3 (checkstop) drives `halt` to its new level.
- R7: Pin index 5 (soft reset) copies its new level into pending bit 3.
- R8: `irq_any` is high in every cycle in which any bit of `pend` is set and low when all are clear.
- R9: Events with pin index 6 or 7 are ignored: no stored level, pending bit or control output changes.
- R10: Pin index 4 (hard reset) produces a one-cycle `hrst_req` on a 0-to-1 change and nothing else; its 1-to-0 change produces no pulse.
- R11: After reset, `pend`, `halt`, `mck_req`, `hrst_req`, `irq_any` and `pin_lvl` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Pin event strobe |
| ev_pin | input | 3 | Pin index of the event (0..5 defined) |
| ev_level | input | 1 | New level of the pin |
| mck_ack | input | 1 | Core acknowledge for the machine-check bit |
| pend | output | 4 | Pending bits: 0 ext, 1 smi, 2 machine check, 3 soft reset |
| irq_any | output | 1 | High while any pending bit is set |
| halt | output | 1 | Core halt from checkstop |
| mck_req | output | 1 | One-cycle pulse when machine check latches |
| hrst_req | output | 1 | One-cycle hard-reset request |
| pin_lvl | output | 6 | Stored level of each pin |

## Verification
A corrupted stored level shows up at the ports one cycle after the next event on that pin: a repeated level would then wrongly toggle a pending bit or halt, or a genuine change would be swallowed, and `pin_lvl` itself diverges at once. A lost or stuck machine-check bit is visible on `pend` and `irq_any` in the cycle after the falling edge or acknowledge, and a doubled pulse appears as `mck_req` or `hrst_req` high for two cycles. Every event is therefore compared one cycle later against a model of the full output state.

// File: rtl/pin_irq_cond.sv
module pin_irq_cond (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_valid,
  input  logic [2:0] ev_pin,
  input  logic       ev_level,
  input  logic       mck_ack,
  output logic [3:0] pend,
  output logic       irq_any,
  output logic       halt,
  output logic       mck_req,
  output logic       hrst_req,
  output logic [5:0] pin_lvl
);
  localparam int P_EXT = 0;
  localparam int P_SMI = 1;
  localparam int P_MCK = 2;
  localparam int P_CKS = 3;
  localparam int P_HRS = 4;
  localparam int P_SRS = 5;

  logic [5:0] sel, hit;
  logic       mck_set;
  logic [3:0] pend_d;

  assign sel     = ev_valid ? (6'b000001 << ev_pin) : 6'b0;
  assign hit     = sel & (pin_lvl ^ {6{ev_level}});
  assign mck_set = hit[P_MCK] & ~ev_level;

  assign pend_d[0] = hit[P_EXT] ? ev_level : pend[0];
  assign pend_d[1] = hit[P_SMI] ? ev_level : pend[1];
  assign pend_d[2] = mck_set | (pend[2] & ~mck_ack);
  assign pend_d[3] = hit[P_SRS] ? ev_level : pend[3];

  assign irq_any = |pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_lvl  <= '0;
      pend     <= '0;
      halt     <= 1'b0;
      mck_req  <= 1'b0;
      hrst_req <= 1'b0;
    end else begin
      pin_lvl  <= pin_lvl ^ hit;
      pend     <= pend_d;
      halt     <= hit[P_CKS] ? ev_level : halt;
      mck_req  <= mck_set;
      hrst_req <= hit[P_HRS] & ev_level;
    end
  end
endmodule

// File: rtl/pin_irq_cond_chk.sv
module pin_irq_cond_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_valid,
  input logic [2:0] ev_pin,
  input logic       ev_level,
  input logic       mck_ack,
  input logic [3:0] pend,
  input logic       irq_any,
  input logic       halt,
  input logic       mck_req,
  input logic       hrst_req,
  input logic [5:0] pin_lvl
);
  AST_REPEAT_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_pin < 3'd6 && ev_level == pin_lvl[ev_pin] && !mck_ack)
    |=> ($stable(pend) && $stable(halt) && $stable(pin_lvl) && !mck_req && !hrst_req)); // R1
  AST_EXT_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_pin == 3'd0) |=> (pend[0] == $past(ev_level))); // R2
  AST_MCK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_pin == 3'd2 && !ev_level && pin_lvl[2]) |=> (pend[2] && mck_req)); // R4
  AST_MCK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mck_req |=> !mck_req); // R4
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (mck_ack && !(ev_valid && ev_pin == 3'd2 && !ev_level && pin_lvl[2])) |=> !pend[2]); // R5
  AST_HALT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_pin == 3'd3) |=> (halt == $past(ev_level))); // R6
  AST_ANY_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_any) |-> (pend != 4'b0)); // R8
  AST_BAD_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_pin >= 3'd6 && !mck_ack)
    |=> ($stable(pin_lvl) && $stable(pend) && $stable(halt) && !hrst_req && !mck_req)); // R9
  AST_HRST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    hrst_req |=> !hrst_req); // R10
endmodule

bind pin_irq_cond pin_irq_cond_chk chk_i (.*);

// File: tb/pin_irq_cond_tb_top.sv
module pin_irq_cond_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_valid = 1'b0;
  logic [2:0] ev_pin = '0;
  logic       ev_level = 1'b0;
  logic       mck_ack = 1'b0;
  logic [3:0] pend;
  logic       irq_any, halt, mck_req, hrst_req;
  logic [5:0] pin_lvl;

  pin_irq_cond dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int         due;
    logic [3:0] pend;
    logic       halt;
    logic       mreq;
    logic       hreq;
    logic [5:0] lvl;
    string      tag;
  } exp_t;

  exp_t       sb[$];
  int         cyc = 0;
  int         checks = 0;
  int         errors = 0;
  logic [5:0] m_lvl = '0;
  logic [3:0] m_pend = '0;
  logic       m_halt = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      logic [13:0] act, xp;
      e = sb.pop_front();
      act = {pend, halt, mck_req, hrst_req, pin_lvl, irq_any};
      xp  = {e.pend, e.halt, e.mreq, e.hreq, e.lvl, |e.pend};
      checks++;
      if (act !== xp) begin
        errors++;
        $display("FAIL %s: actual pend=%b halt=%b mreq=%b hreq=%b lvl=%b any=%b expected pend=%b halt=%b mreq=%b hreq=%b lvl=%b any=%b",
                 e.tag, pend, halt, mck_req, hrst_req, pin_lvl, irq_any,
                 e.pend, e.halt, e.mreq, e.hreq, e.lvl, |e.pend);
      end
    end
  end

  task automatic step(input logic v, input logic [2:0] p, input logic l,
                      input logic ack, input string tag);
    exp_t e;
    logic mr, hr;
    @(negedge clk);
    ev_valid = v; ev_pin = p; ev_level = l; mck_ack = ack;
    mr = 1'b0; hr = 1'b0;
    if (ack) m_pend[2] = 1'b0;
    if (v && p < 3'd6 && l != m_lvl[p]) begin
      case (p)
        3'd0: m_pend[0] = l;
        3'd1: m_pend[1] = l;
        3'd2: if (!l) begin m_pend[2] = 1'b1; mr = 1'b1; end
        3'd3: m_halt = l;
        3'd4: hr = l;
        default: m_pend[3] = l;
      endcase
      m_lvl[p] = l;
    end
    e.due = cyc + 1; e.pend = m_pend; e.halt = m_halt;
    e.mreq = mr; e.hreq = hr; e.lvl = m_lvl; e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        checks++;
        if ({pend, halt, mck_req, hrst_req, pin_lvl, irq_any} !== 14'b0) begin
          errors++;
          $display("FAIL R11: actual pend=%b halt=%b lvl=%b expected all zero", pend, halt, pin_lvl);
        end
        rst_n = 1'b1;
        step(1, 3'd0, 1, 0, "R2 ext rise");
        step(1, 3'd0, 1, 0, "R1 ext repeat");
        step(0, 3'd0, 0, 0, "R1 no event");
        step(1, 3'd0, 0, 0, "R2 ext fall R8");
        step(1, 3'd1, 1, 0, "R3 smi rise");
        step(1, 3'd1, 0, 0, "R3 smi fall");
        step(1, 3'd2, 1, 0, "R4 mck rise no latch");
        step(1, 3'd2, 0, 0, "R4 mck fall latch");
        step(0, 3'd0, 0, 0, "R4 pulse ends");
        step(1, 3'd2, 0, 0, "R1 mck repeat low");
        step(0, 3'd0, 0, 1, "R5 ack clears");
        step(1, 3'd2, 1, 0, "R4 mck rise again");
        step(1, 3'd2, 0, 1, "R5 fall beats ack");
        step(0, 3'd0, 0, 1, "R5 ack");
        step(1, 3'd3, 1, 0, "R6 halt on");
        step(1, 3'd3, 1, 0, "R1 halt repeat");
        step(1, 3'd3, 0, 0, "R6 halt off");
        step(1, 3'd5, 1, 0, "R7 srst rise");
        step(1, 3'd0, 1, 0, "R8 two pending");
        step(1, 3'd5, 0, 0, "R7 srst fall");
        step(1, 3'd0, 0, 0, "R8 none pending");
        step(1, 3'd6, 1, 0, "R9 pin 6 ignored");
        step(1, 3'd7, 1, 0, "R9 pin 7 ignored");
        step(1, 3'd4, 1, 0, "R10 hrst rise");
        step(0, 3'd0, 0, 0, "R10 pulse ends");
        step(1, 3'd4, 0, 0, "R10 hrst fall no pulse");
        step(0, 3'd0, 0, 0, "R1 idle");
        repeat (3) @(negedge clk);
      end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule